// File: doc/BRIEF.md
# Frame Coadder with Alternating Accumulator Regions

This block sums successive frames of 16-bit detector samples pixel by pixel. Samples arrive on a valid/ready stream whose first sample of each frame is flagged as start of frame and whose last is flagged as end of frame. Once a programmed number of frames has been summed, the finished sum image is released for readout on a 128-bit beat stream. Meanwhile the next sum builds up in a different region of the accumulator memory.

The accumulator memory holds four regions, and two of them take turns. While one region gathers the current sum, the other holds the previous result and is drained to the wide bus at whatever pace the downstream side allows. The drain only has to finish before the next sum completes. If it has not finished by then, an overrun pulse is raised and the new result replaces the old one. The first frame of every sum writes samples directly over the stored value, so no clear pass is needed between sums.

Top module: `frame_coadder`

## Requirements
- R1: While reset is asserted, `m_valid`, `ovr_err` and `s_ready` are 0. From the first clock edge after reset is released, `s_ready` is 1 and remains 1.
- R2: A sample is accepted in each cycle with `s_valid` and `s_ready` both high. A sample carrying `s_sof` has pixel index 0, and each later accepted sample has the next index. The sample value, zero-extended, is added to the sum for that pixel.
- R3: In the first frame of a sum, each sample replaces the stored value for its pixel, so nothing from an earlier sum is carried forward.
- R4: A frame ends with the sample that carries `s_eof`. A sum completes at the end of its N-th frame, where N is the value of `coadd_n` at the start-of-frame sample of the sum's first frame. A value of 0 is treated as 1.
- R5: Samples whose pixel index is NPIX or higher leave every sum unchanged.
- R6: Sums are 32-bit unsigned. Fifteen full-scale samples (16'hFFFF) sum to 15 × 65535 exactly.
- R7: In the cycle after the sample that completes a sum, readout of that sum begins. Readout of one sum runs while the next sum accumulates, and the readout data is not disturbed by the new accumulation.
- R8: Readout takes NPIX/4 beats. Beat b carries the sum of pixel 4b+k in bits [32k+31:32k] for k = 0 to 3, and `m_last` is high only on the final beat. A beat is taken when `m_valid` and `m_ready` are both high. While the beat waits, `m_valid` and `m_data` do not change.
- R9: If a sum completes while a readout is still unfinished, `ovr_err` is high for exactly the next cycle. The unfinished readout is abandoned, and readout of the new sum starts at beat 0.
- R10: If the final beat is taken in the same cycle as a sum completes, this is not an overrun: `ovr_err` stays 0.
- R11: Cycles with `s_valid` low change no sum and no counter, so samples may arrive with arbitrary gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| coadd_n | input | 4 | Number of frames per sum, sampled at the start of a sum's first frame |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take a sample |
| s_data | input | 16 | Converter sample |
| s_sof | input | 1 | Sample is the first of a frame |
| s_eof | input | 1 | Sample is the last of a frame |
| m_valid | output | 1 | Readout beat valid |
| m_ready | input | 1 | Downstream takes the beat |
| m_data | output | 128 | Four 32-bit pixel sums, lowest pixel in the low bits |
| m_last | output | 1 | Final beat of the sum image |
| ovr_err | output | 1 | One-cycle pulse: a sum completed before the previous readout finished |

## Verification
Two events can fall in the same cycle: completion of a sum and the transfer of the final readout beat of the previous sum. The bench provokes this in a dedicated phase. It holds `m_ready` low on the final beat and raises it only in the cycle that presents the completing end-of-frame sample. The result is judged correct if `ovr_err` stays low and the next beats carry the new sums from beat 0. A separate phase stalls readout across several completions to show the overrun pulse and the restart.

// File: rtl/coadd_pkg.sv
package coadd_pkg;
    localparam int unsigned NUM_REGIONS = 4;

    typedef logic [1:0] region_t;

    function automatic region_t pick_region(input logic sel, input int unsigned ra,
                                            input int unsigned rb);
        return sel ? region_t'(rb) : region_t'(ra);
    endfunction
endpackage

// File: rtl/coadd_ctrl.sv
module coadd_ctrl
    import coadd_pkg::*;
#(
    parameter int unsigned NPIX  = 16,
    parameter int unsigned CNT_W = 4,
    parameter int unsigned AW    = 4,
    parameter int unsigned REG_A = 0,
    parameter int unsigned REG_B = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] coadd_n,
    input  logic             s_valid,
    input  logic             s_sof,
    input  logic             s_eof,
    output logic             s_ready,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic             wr_first,
    output region_t          acc_reg,
    output region_t          drn_reg,
    output logic             done
);
    localparam int unsigned PCW = $clog2(NPIX + 1);

    typedef struct packed {
        logic [PCW-1:0]   pix;
        logic [CNT_W-1:0] frm;
        logic [CNT_W-1:0] cnt;
        logic             sel;
        logic             rdy;
    } ctrl_t;

    ctrl_t            st_d, st_q;
    logic             fire, first_frm, is_last, in_range;
    logic [PCW-1:0]   idx;
    logic [CNT_W-1:0] new_cnt, cur_cnt;

    always_comb begin
        st_d      = st_q;
        st_d.rdy  = 1'b1;
        fire      = s_valid && st_q.rdy;
        first_frm = (st_q.frm == '0);
        new_cnt   = (coadd_n == '0) ? CNT_W'(1) : coadd_n;
        cur_cnt   = (first_frm && s_sof) ? new_cnt : st_q.cnt;
        idx       = s_sof ? '0 : st_q.pix;
        in_range  = (idx < PCW'(NPIX));
        is_last   = (st_q.frm == (cur_cnt - CNT_W'(1)));
        wr_en     = fire && in_range;
        wr_addr   = idx[AW-1:0];
        wr_first  = first_frm;
        done      = 1'b0;
        if (fire) begin
            if (first_frm && s_sof) begin
                st_d.cnt = new_cnt;
            end
            st_d.pix = in_range ? (idx + PCW'(1)) : idx;
            if (s_eof) begin
                st_d.pix = '0;
                if (is_last) begin
                    st_d.frm = '0;
                    st_d.sel = ~st_q.sel;
                    done     = 1'b1;
                end else begin
                    st_d.frm = st_q.frm + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pix: '0, frm: '0, cnt: CNT_W'(1), sel: 1'b0, rdy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign s_ready = st_q.rdy;
    assign acc_reg = pick_region(st_q.sel, REG_A, REG_B);
    assign drn_reg = pick_region(st_q.sel, REG_B, REG_A);
endmodule

// File: rtl/coadd_mem.sv
module coadd_mem
    import coadd_pkg::*;
#(
    parameter int unsigned PIX_W = 16,
    parameter int unsigned SUM_W = 32,
    parameter int unsigned NPIX  = 16,
    parameter int unsigned LANES = 4,
    parameter int unsigned AW    = 4,
    parameter int unsigned LB    = 2,
    parameter int unsigned BW    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  region_t                wr_reg,
    input  logic [AW-1:0]          wr_addr,
    input  logic                   wr_first,
    input  logic [PIX_W-1:0]       wr_data,
    input  region_t                rd_reg,
    input  logic [BW-1:0]          rd_beat,
    output logic [LANES*SUM_W-1:0] rd_data
);
    logic [SUM_W-1:0] mem_d [NUM_REGIONS][NPIX];
    logic [SUM_W-1:0] mem_q [NUM_REGIONS][NPIX];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_reg][wr_addr] = wr_first ? SUM_W'(wr_data)
                                              : mem_q[wr_reg][wr_addr] + SUM_W'(wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign rd_data[k*SUM_W +: SUM_W] = mem_q[rd_reg][{rd_beat, LB'(k)}];
    end
endmodule

// File: rtl/coadd_rdout.sv
module coadd_rdout #(
    parameter int unsigned BEATS = 4,
    parameter int unsigned BW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          m_ready,
    output logic          m_valid,
    output logic          m_last,
    output logic          ovr_err,
    output logic [BW-1:0] rd_beat
);
    typedef struct packed {
        logic          busy;
        logic          ovr;
        logic [BW-1:0] beat;
    } rd_t;

    rd_t  st_d, st_q;
    logic take, fin, at_end;

    always_comb begin
        st_d     = st_q;
        st_d.ovr = 1'b0;
        at_end   = (st_q.beat == BW'(BEATS - 1));
        take     = st_q.busy && m_ready;
        fin      = take && at_end;
        if (take) begin
            st_d.beat = st_q.beat + BW'(1);
            if (fin) begin
                st_d.busy = 1'b0;
            end
        end
        if (start) begin
            st_d.ovr  = st_q.busy && !fin;
            st_d.busy = 1'b1;
            st_d.beat = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, ovr: 1'b0, beat: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign m_valid = st_q.busy;
    assign m_last  = st_q.busy && at_end;
    assign ovr_err = st_q.ovr;
    assign rd_beat = st_q.beat;
endmodule

// File: rtl/frame_coadder.sv
module frame_coadder
    import coadd_pkg::*;
#(
    parameter int unsigned PIX_W = 16,
    parameter int unsigned SUM_W = 32,
    parameter int unsigned NPIX  = 16,
    parameter int unsigned CNT_W = 4,
    parameter int unsigned BUS_W = 128,
    parameter int unsigned REG_A = 0,
    parameter int unsigned REG_B = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] coadd_n,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [PIX_W-1:0] s_data,
    input  logic             s_sof,
    input  logic             s_eof,
    output logic             m_valid,
    input  logic             m_ready,
    output logic [BUS_W-1:0] m_data,
    output logic             m_last,
    output logic             ovr_err
);
    localparam int unsigned LANES = BUS_W / SUM_W;
    localparam int unsigned BEATS = NPIX / LANES;
    localparam int unsigned AW    = $clog2(NPIX);
    localparam int unsigned LB    = $clog2(LANES);
    localparam int unsigned BW    = AW - LB;

    logic          wr_en, wr_first, coadd_done;
    logic [AW-1:0] wr_addr;
    logic [BW-1:0] rd_beat;
    region_t       acc_reg, drn_reg;

    coadd_ctrl #(
        .NPIX(NPIX), .CNT_W(CNT_W), .AW(AW), .REG_A(REG_A), .REG_B(REG_B)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .coadd_n(coadd_n), .s_valid(s_valid),
        .s_sof(s_sof), .s_eof(s_eof), .s_ready(s_ready), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_first(wr_first), .acc_reg(acc_reg),
        .drn_reg(drn_reg), .done(coadd_done)
    );

    coadd_mem #(
        .PIX_W(PIX_W), .SUM_W(SUM_W), .NPIX(NPIX), .LANES(LANES),
        .AW(AW), .LB(LB), .BW(BW)
    ) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(acc_reg),
        .wr_addr(wr_addr), .wr_first(wr_first), .wr_data(s_data),
        .rd_reg(drn_reg), .rd_beat(rd_beat), .rd_data(m_data)
    );

    coadd_rdout #(
        .BEATS(BEATS), .BW(BW)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .start(coadd_done), .m_ready(m_ready),
        .m_valid(m_valid), .m_last(m_last), .ovr_err(ovr_err), .rd_beat(rd_beat)
    );
endmodule

// File: rtl/coadd_chk.sv
module coadd_chk #(
    parameter int unsigned BUS_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_ready,
    input logic             m_valid,
    input logic             m_ready,
    input logic             m_last,
    input logic [BUS_W-1:0] m_data,
    input logic             ovr_err,
    input logic             done,
    input logic [1:0]       acc_reg,
    input logic [1:0]       drn_reg
);
    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> s_ready); // R1

    AST_REGIONS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        acc_reg != drn_reg); // R7

    AST_SWAP_TO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (drn_reg == $past(acc_reg))); // R7

    AST_READOUT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> m_valid); // R7

    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready && !done) |=> (m_valid && $stable(m_data))); // R8

    AST_LAST_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        m_last |-> m_valid); // R8

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_err |-> ($past(done) && $past(m_valid))); // R9

    AST_FIN_NOT_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && m_valid && m_ready && m_last) |=> !ovr_err); // R10
endmodule

bind frame_coadder coadd_chk #(.BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .m_valid(m_valid),
    .m_ready(m_ready), .m_last(m_last), .m_data(m_data), .ovr_err(ovr_err),
    .done(coadd_done), .acc_reg(acc_reg), .drn_reg(drn_reg)
);

// File: tb/tb_frame_coadder.sv
module tb_frame_coadder;
    localparam int NPIX  = 16;
    localparam int LANES = 4;
    localparam int BEATS = NPIX / LANES;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   coadd_n = 4'd1;
    logic         s_valid = 1'b0;
    logic         s_ready;
    logic [15:0]  s_data = '0;
    logic         s_sof = 1'b0;
    logic         s_eof = 1'b0;
    logic         m_valid;
    logic         m_ready = 1'b0;
    logic [127:0] m_data;
    logic         m_last;
    logic         ovr_err;

    always #5 clk = ~clk;

    frame_coadder dut (
        .clk(clk), .rst_n(rst_n), .coadd_n(coadd_n), .s_valid(s_valid),
        .s_ready(s_ready), .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
        .ovr_err(ovr_err)
    );

    int n_chk = 0, n_bad = 0, n_ovr = 0, n_coin = 0;
    int rmode = 1;
    bit [31:0] acc_m  [NPIX];
    bit [31:0] snap_m [NPIX];
    int  pix_m = 0, frm_m = 0, cnt_m = 1, rb_m = 0, idx_m = 0, cur_m = 1;
    bit  busy_m = 0, ovr_exp = 0, fire_m, compl_m, first_m, fin_m;
    bit  rst_seen = 0;

    task automatic chk(input bit ok, input string what, input longint unsigned act,
                       input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    always @(posedge clk) rst_seen <= rst_n;

    // Reference model and checker, evaluated between edges.
    always @(negedge clk) begin
        if (!rst_n || !rst_seen) begin
            chk(m_valid == 1'b0, "R1 m_valid in reset", m_valid, 0);
            chk(ovr_err == 1'b0, "R1 ovr_err in reset", ovr_err, 0);
            chk(s_ready == 1'b0, "R1 s_ready in reset", s_ready, 0);
            busy_m = 0; ovr_exp = 0; pix_m = 0; frm_m = 0; cnt_m = 1; rb_m = 0;
        end else begin
            chk(s_ready == 1'b1, "R1 s_ready after reset", s_ready, 1);
            chk(m_valid == busy_m, "R7 m_valid", m_valid, busy_m);
            chk(ovr_err == ovr_exp, "R9 R10 ovr_err", ovr_err, ovr_exp);
            if (ovr_err) n_ovr++;
            fire_m  = s_valid && s_ready;
            first_m = (frm_m == 0);
            cur_m   = (first_m && s_sof) ? ((coadd_n == 0) ? 1 : int'(coadd_n)) : cnt_m;
            compl_m = fire_m && s_eof && (frm_m == cur_m - 1);
            case (rmode)
                0:       m_ready = (($urandom % 100) < 70);
                1:       m_ready = 1'b1;
                2:       m_ready = 1'b0;
                default: m_ready = (rb_m != BEATS - 1) || compl_m;
            endcase
            fin_m = 0;
            if (busy_m) begin
                for (int k = 0; k < LANES; k++) begin
                    chk(m_data[k*32 +: 32] == snap_m[rb_m*LANES + k],
                        "R2 R3 R4 R5 R6 R8 R11 sum lane",
                        m_data[k*32 +: 32], snap_m[rb_m*LANES + k]);
                end
                chk(m_last == (rb_m == BEATS - 1), "R8 m_last", m_last, rb_m == BEATS - 1);
                if (m_ready) begin
                    if (rb_m == BEATS - 1) begin
                        fin_m = 1; busy_m = 0;
                    end else begin
                        rb_m++;
                    end
                end
            end else begin
                chk(m_last == 1'b0, "R8 m_last idle", m_last, 0);
            end
            if (fire_m) begin
                if (first_m && s_sof) cnt_m = cur_m;
                idx_m = s_sof ? 0 : pix_m;
                if (idx_m < NPIX) begin
                    acc_m[idx_m] = first_m ? 32'(s_data) : acc_m[idx_m] + 32'(s_data);
                    pix_m = idx_m + 1;
                end else begin
                    pix_m = idx_m;
                end
                if (s_eof) begin
                    pix_m = 0;
                    frm_m = compl_m ? 0 : frm_m + 1;
                end
            end
            ovr_exp = 0;
            if (compl_m) begin
                ovr_exp = busy_m;
                if (fin_m) n_coin++;
                snap_m = acc_m;
                busy_m = 1; rb_m = 0;
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            s_valid = 0; s_sof = 0; s_eof = 0;
        end
    endtask

    task automatic send_frame(input int npx, input int gap, input bit full);
        for (int i = 0; i < npx; i++) begin
            while (($urandom % 100) < gap) idle(1);
            @(posedge clk); #2;
            s_valid = 1; s_sof = (i == 0); s_eof = (i == npx - 1);
            s_data = full ? 16'hFFFF : 16'($urandom);
            if (!full && ($urandom % 8) == 0) s_data = 16'hFFFF;
        end
    endtask

    task automatic run_coadd(input int cnt, input int npx, input int gap, input bit full);
        coadd_n = 4'(cnt);
        for (int f = 0; f < ((cnt == 0) ? 1 : cnt); f++) send_frame(npx, gap, full);
        idle(1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R2 R3 R4 R5 R7 R11: random sums, gaps, overlong frames, random drain pace
        rmode = 0;
        for (int c = 0; c < 24; c++)
            run_coadd(1 + int'($urandom % 3), (($urandom % 4) == 0) ? NPIX + 3 : NPIX, 30, 0);
        // R6: largest count with full-scale samples
        rmode = 1;
        run_coadd(15, NPIX, 0, 1);
        idle(12);
        // R4: count 0 acts as 1
        run_coadd(0, NPIX, 10, 0);
        run_coadd(0, NPIX, 0, 0);
        idle(12);
        // R9: readout stalled across completions
        rmode = 2;
        for (int c = 0; c < 3; c++) run_coadd(1, NPIX, 0, 0);
        rmode = 1;
        idle(12);
        // R10: final beat taken in the completing cycle
        rmode = 3;
        for (int c = 0; c < 4; c++) run_coadd(1, NPIX, 10, 0);
        rmode = 1;
        idle(12);
        // R8 R11: heavy gaps and random back-pressure
        rmode = 0;
        for (int c = 0; c < 10; c++) run_coadd(1 + int'($urandom % 4), NPIX, 60, 0);
        rmode = 1;
        idle(20);
        chk(n_ovr >= 2, "R9 overrun pulses seen", longint'(n_ovr), 2);
        chk(n_coin >= 3, "R10 coincident finish seen", longint'(n_coin), 3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule